// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block derives the periodic-interrupt events of a PC-style real-time clock from a 32.768 kHz clock enable. A 4-bit rate code and an enable bit, both taken from the clock's control registers, select one of fifteen power-of-two periods. Each time the selected period elapses, the block emits a single-cycle event pulse. The neighbouring register block turns that pulse into status flags and an interrupt request.

Event times are not measured from the moment software writes the controls. A free-running 15-bit reference count advances on every reference enable, whether or not the divider is enabled. An event falls on the reference enable that takes the low bits of that count, one fewer bits than the effective rate code, to zero. As a result, enabling the divider, disabling it or changing the rate moves the next event to the next multiple of the new period on the same time base. Rate codes 1 and 2 are treated as the slower codes 8 and 9.

Top module: `rtc_periodic_tick`

## Requirements
- R1: With rate code 0 no event pulse occurs, whatever the enable bit, and `running` is 0.
- R2: With the enable input at 0 no event pulse occurs, whatever the rate code, and `running` is 0.
- R3: Rate code 1 runs with the period of code 8 (128 reference ticks), and rate code 2 runs with the period of code 9 (256 reference ticks).
- R4: For effective codes 3 to 15 the period is 2^(code-1) reference ticks. Code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: The reference count starts at 0 after reset and advances on every reference tick, including while the divider is disabled. An event occurs exactly on a tick that moves the count to a value whose low (code-1) bits are all zero.
- R6: The event pulse is high for one clock cycle. It is high in the cycle that directly follows the clock edge at which `ref_tick` was sampled high, and at no other time.
- R7: A change of rate code or enable bit takes effect at the next reference tick. It produces no pulse in the cycle of the change. The first event after the change falls on the next boundary of the new period.
- R8: `running` is 1 exactly when the rate code is nonzero and the enable input is 1. It follows the inputs without delay.
- R9: During and directly after reset, `event_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| rate_sel | input | 4 | Rate code. 0 means off, 1 and 2 alias to 8 and 9, and 3 to 15 give a period of 2^(code-1) ticks |
| pie_en | input | 1 | Periodic-event enable |
| event_pulse | output | 1 | One-cycle pulse at each period boundary |
| running | output | 1 | High while the divider is enabled |

## Verification
The divider is exercised with the enable on and rate code 0, and with a nonzero code and the enable off. These two patterns show that each control blocks events on its own. Sweeps over the fastest code, a middle code, both aliased codes and the slowest code separate a correct period formula from an off-by-one exponent or a missing alias. The bench pauses the enable for a number of ticks that is not a multiple of the period. This shows whether event times come from the free-running count or restart from the moment of enabling. Rate changes made between ticks and on a tick cycle show whether a control write can cause a pulse of its own or leave the old period in force.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  localparam int PT_CODE_W = 4;
  localparam int PT_REF_W  = 15;
  // Codes below this value (except 0) are remapped upward by PT_ALIAS_ADD.
  localparam int PT_ALIAS_LIMIT = 3;
  localparam int PT_ALIAS_ADD   = 7;

  // Effective rate code after the low-code remapping.
  function automatic logic [PT_CODE_W-1:0] eff_code(input logic [PT_CODE_W-1:0] code);
    if (code != '0 && int'(code) < PT_ALIAS_LIMIT)
      return code + PT_CODE_W'(PT_ALIAS_ADD);
    return code;
  endfunction

  // Mask of the low (code-1) reference bits that must all be set before an event.
  function automatic logic [PT_REF_W-1:0] period_mask(input logic [PT_CODE_W-1:0] code);
    logic [PT_REF_W-1:0] m;
    m = '0;
    for (int i = 0; i < PT_REF_W; i++)
      if (i < int'(code) - 1) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ptick_ref_counter.sv
module ptick_ref_counter #(
  parameter int W = ptick_pkg::PT_REF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (tick_en) count <= count + W'(1);
  end

  // R5: the reference count moves only on a reference tick
  a_r5_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(count));
endmodule

// File: rtl/ptick_rate_decode.sv
module ptick_rate_decode
  import ptick_pkg::*;
(
  input  logic [PT_CODE_W-1:0] rate_sel,
  input  logic                 pie_en,
  output logic                 run,
  output logic [PT_REF_W-1:0]  mask
);
  logic [PT_CODE_W-1:0] eff;

  assign eff  = eff_code(rate_sel);
  assign run  = pie_en && (rate_sel != '0);
  assign mask = run ? period_mask(eff) : '0;
endmodule

// File: rtl/ptick_boundary_detect.sv
module ptick_boundary_detect
  import ptick_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                run,
  input  logic [PT_REF_W-1:0] mask,
  input  logic [PT_REF_W-1:0] count,
  output logic                pulse
);
  logic at_edge;

  // The current tick takes the masked low bits from all ones to zero.
  assign at_edge = run && tick_en && ((count & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= at_edge;
  end

  // R5: every event lands on a period boundary of the reference count
  a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> ((count & $past(mask)) == '0));
  // R6: a pulse follows a reference tick
  a_r6_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(tick_en));
endmodule

// File: rtl/rtc_periodic_tick.sv
module rtc_periodic_tick
  import ptick_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_tick,
  input  logic [PT_CODE_W-1:0] rate_sel,
  input  logic                 pie_en,
  output logic                 event_pulse,
  output logic                 running
);
  logic [PT_REF_W-1:0] ref_count;
  logic [PT_REF_W-1:0] lo_mask;
  logic                run_w;

  ptick_ref_counter #(.W(PT_REF_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (ref_tick),
    .count   (ref_count)
  );

  ptick_rate_decode u_decode (
    .rate_sel (rate_sel),
    .pie_en   (pie_en),
    .run      (run_w),
    .mask     (lo_mask)
  );

  ptick_boundary_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (ref_tick),
    .run     (run_w),
    .mask    (lo_mask),
    .count   (ref_count),
    .pulse   (event_pulse)
  );

  assign running = run_w;

  // R1 R2: no event unless the divider was enabled at the tick
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |-> $past(running));
  // R6: an event lasts a single cycle (shortest period is 4 ticks)
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    event_pulse |=> !event_pulse);
  // R3: code 1 uses the code-8 boundary width
  a_r3_alias_one: assert property (@(posedge clk) disable iff (!rst_n)
    (running && rate_sel == 4'd1) |-> (lo_mask == 15'h007F));
  // R9: no event in the cycle after reset is released
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !event_pulse);
endmodule

// File: tb/tb_rtc_periodic_tick.sv
`timescale 1ns/1ps
module tb_rtc_periodic_tick;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       pie_en = 1'b0;
  logic       event_pulse;
  logic       running;

  int total = 0;
  int bad = 0;
  int ticks_driven = 0;
  int ticks_seen = 0;
  int phase_events = 0;
  logic [14:0] model_ref = '0;
  int exp_q[$];
  string cur_req = "R9";
  bit done = 0;

  always #2.5 clk = ~clk;

  rtc_periodic_tick dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_sel(rate_sel),
    .pie_en(pie_en), .event_pulse(event_pulse), .running(running)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bench_period(input logic [3:0] r);
    int ec;
    ec = (r == 4'd1) ? 8 : (r == 4'd2) ? 9 : int'(r);
    return 1 << (ec - 1);
  endfunction

  // Driver: one reference tick, predicting the event from the bench's own count.
  task automatic do_tick();
    int per;
    @(negedge clk);
    ref_tick = 1'b1;
    ticks_driven++;
    if (pie_en && rate_sel != 4'd0) begin
      per = bench_period(rate_sel);
      if ((int'(model_ref) % per) == per - 1) exp_q.push_back(ticks_driven);
    end
    model_ref = model_ref + 15'd1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic set_ctl(input logic [3:0] r, input logic p);
    @(negedge clk);
    rate_sel = r;
    pie_en = p;
  endtask

  task automatic end_phase(input string req);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Monitor
  always @(posedge clk) begin
    logic tk;
    int e;
    tk = ref_tick && rst_n;
    #1;
    if (tk) ticks_seen++;
    if (!done && rst_n) begin
      if (event_pulse) begin
        phase_events++;
        if (exp_q.size() == 0) check(1'b0, cur_req, ticks_seen, -1);
        else begin
          e = exp_q.pop_front();
          check(e == ticks_seen, cur_req, ticks_seen, e);
        end
      end else if (exp_q.size() != 0 && exp_q[0] <= ticks_seen) begin
        e = exp_q.pop_front();
        check(1'b0, cur_req, 0, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(event_pulse == 1'b0, "R9", event_pulse, 0);
    check(running == 1'b0, "R8", running, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(event_pulse == 1'b0, "R9", event_pulse, 0);

    // R1: enable on, code 0
    cur_req = "R1"; set_ctl(4'd0, 1'b1);
    #1 check(running == 1'b0, "R1", running, 0);
    phase_events = 0; ticks(100); end_phase("R1");
    check(phase_events == 0, "R1", phase_events, 0);

    // R2: code set, enable off
    cur_req = "R2"; set_ctl(4'd6, 1'b0);
    #1 check(running == 1'b0, "R2", running, 0);
    phase_events = 0; ticks(100); end_phase("R2");
    check(phase_events == 0, "R2", phase_events, 0);

    // R4 fastest code, R8 running
    cur_req = "R4"; set_ctl(4'd3, 1'b1);
    #1 check(running == 1'b1, "R8", running, 1);
    phase_events = 0; ticks(64); end_phase("R4");
    check(phase_events == 16, "R4", phase_events, 16);

    cur_req = "R4"; set_ctl(4'd6, 1'b1);
    phase_events = 0; ticks(200); end_phase("R4");
    check(phase_events >= 6, "R4", phase_events, 6);

    // R3 aliased codes
    cur_req = "R3"; set_ctl(4'd1, 1'b1);
    phase_events = 0; ticks(600); end_phase("R3");
    check(phase_events >= 4, "R3", phase_events, 4);
    cur_req = "R3"; set_ctl(4'd2, 1'b1);
    phase_events = 0; ticks(600); end_phase("R3");
    check(phase_events >= 2, "R3", phase_events, 2);

    // R5 pause for a non-multiple of the period, then resume
    cur_req = "R5"; set_ctl(4'd5, 1'b0);
    ticks(37);
    set_ctl(4'd5, 1'b1);
    phase_events = 0; ticks(100); end_phase("R5");
    check(phase_events >= 6, "R5", phase_events, 6);

    // R7 change between ticks, then on a tick cycle
    cur_req = "R7"; set_ctl(4'd3, 1'b1);
    ticks(9);
    set_ctl(4'd7, 1'b1);
    phase_events = 0; ticks(150);
    @(negedge clk);
    rate_sel = 4'd4; ref_tick = 1'b1;
    ticks_driven++;
    if ((int'(model_ref) % 8) == 7) exp_q.push_back(ticks_driven);
    model_ref = model_ref + 15'd1;
    @(negedge clk); ref_tick = 1'b0;
    ticks(40); end_phase("R7");
    check(phase_events >= 6, "R7", phase_events, 6);

    // R4 slowest code
    cur_req = "R4"; set_ctl(4'd15, 1'b1);
    phase_events = 0; ticks(17000); end_phase("R4");
    check(phase_events >= 1, "R4", phase_events, 1);

    set_ctl(4'd0, 1'b0);
    #1 check(running == 1'b0, "R8", running, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule